// File: doc/BRIEF.md
# Double-Buffered Serial Receiver

This block turns an asynchronous serial line into parallel characters. A 16x oversampling tick comes from a baud divisor shared with the transmitter. It paces a small state machine. That machine confirms the start bit, gathers 5 to 8 data bits with the least significant bit first, checks an optional parity bit and then checks the stop bit. Each finished character moves from the shift register into a separate holding register, so the next character can be assembled while the host still holds the previous one.

The holding register faces the host as a valid/ready stream. `rx_valid` means a character is waiting. A cycle with both `rx_valid` and `rx_ready` high takes the character. There is no back-pressure on the serial line, because the line cannot be stalled. If a new character finishes while the old one has not been taken, the new one replaces it and an overrun flag is raised. Parity and framing flags travel with the character they describe. Word length, parity enable, parity polarity and forced parity come in as plain line-control inputs. They are captured when each start bit is confirmed.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, `rx_valid`, `rx_perr`, `rx_ferr` and `rx_ovr` are all low.
- R2: A falling edge on `rxd` is accepted as a start bit only if the line is still low at the 8th tick after it is seen. If the line is high at that point, the receiver returns to idle and no character is produced.
- R3: Data bits are sampled once every 16 ticks, starting 16 ticks after the start-bit check. The first data bit is bit 0 of `rx_data`. `lc_wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of `rx_data` read as zero.
- R4: When `lc_par_en` is 1, one parity bit follows the data, and `rx_perr` is set for a bad parity bit. With `lc_par_stick`=0, `lc_par_even`=1 asks for an even count of ones over data and parity, and `lc_par_even`=0 asks for an odd count. With `lc_par_stick`=1, the parity bit must be 0 when `lc_par_even`=1 and must be 1 when `lc_par_even`=0. When `lc_par_en` is 0, no parity bit is expected and `rx_perr` stays low.
- R5: Only the first stop bit is checked. If it is low, `rx_ferr` is set with that character.
- R6: A completed character is copied into the holding register and `rx_valid` rises. A new character can be received in full while the previous one waits.
- R7: A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid` and `rx_ovr`. `rx_ready` while `rx_valid` is low has no effect.
- R8: If a character completes while `rx_valid` is high and is not being taken in that cycle, `rx_ovr` is set. The new character and its flags replace the held ones.
- R9: While `rx_valid` is high, not taken and no new character completes, `rx_data`, `rx_perr` and `rx_ferr` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| lc_wlen | input | 2 | Word length select (0..3 gives 5..8 bits) |
| lc_par_en | input | 1 | Parity bit present and checked |
| lc_par_even | input | 1 | Even parity, or forced-0 parity when stick is set |
| lc_par_stick | input | 1 | Forced (sticky) parity |
| rx_data | output | 8 | Held character, right-aligned |
| rx_valid | output | 1 | Data ready |
| rx_ready | input | 1 | Host read strobe |
| rx_perr | output | 1 | Parity error of held character |
| rx_ferr | output | 1 | Framing error of held character |
| rx_ovr | output | 1 | Overrun since last read |

## Verification
The bench builds the block with its default 16x oversampling, an 8-bit data width and a two-stage synchronizer. It drives `baud_tick` only on every third clock, so the bench can tell whether the state machine advances on the enable rather than on the clock. Every word length and every parity mode is reached, including both forced-parity levels. A low stop bit is followed directly by an idle line, which makes the receiver read the tail of that stop bit as a false start. A character is also read back halfway through the next one, which exercises the double buffer with no overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } rx_cfg_t;

  // acc: xor of all received data bits, pbit: received parity bit
  function automatic logic parity_bad(input rx_cfg_t cfg, input logic acc,
                                      input logic pbit);
    logic bad;
    if (!cfg.par_en)        bad = 1'b0;
    else if (cfg.par_stick) bad = pbit ^ ~cfg.par_even;
    else                    bad = (acc ^ pbit) ^ ~cfg.par_even;
    return bad;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  rx_cfg_t           cfg,
  output logic              done,
  output logic [DATA_W-1:0] c_data,
  output logic              c_perr,
  output logic              c_ferr
);
  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int MID      = OVERSAMPLE / 2;
  localparam int BITS_W   = $clog2(DATA_W + 1);
  localparam int MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BITS_W-1:0] bitn_q;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q;
  logic              perr_q;
  rx_cfg_t           cfg_q;

  logic [BITS_W-1:0] nbits;
  logic [BITS_W-1:0] drop;
  logic              at_sample;

  assign nbits     = BITS_W'(MIN_BITS) + BITS_W'(cfg_q.wlen);
  assign drop      = BITS_W'(DATA_W) - nbits;
  assign at_sample = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      cfg_q   <= '0;
      done    <= 1'b0;
      c_data  <= '0;
      c_perr  <= 1'b0;
      c_ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rxd_s) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              if (rxd_s) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
                bitn_q  <= '0;
                acc_q   <= 1'b0;
                perr_q  <= 1'b0;
                cfg_q   <= cfg;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_sample) begin
              cnt_q <= '0;
              sh_q  <= {rxd_s, sh_q[DATA_W-1:1]};
              acc_q <= acc_q ^ rxd_s;
              if (bitn_q == nbits - 1'b1) begin
                state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
              end else begin
                bitn_q <= bitn_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_sample) begin
              cnt_q   <= '0;
              perr_q  <= parity_bad(cfg_q, acc_q, rxd_s);
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_sample) begin
              cnt_q   <= '0;
              done    <= 1'b1;
              c_data  <= sh_q >> drop;
              c_perr  <= perr_q;
              c_ferr  <= ~rxd_s;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: data phase entered only when the start check saw a low line
  p_confirm_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_START && state_q == ST_DATA) |-> !$past(rxd_s));

  // R3: the state machine only moves on a tick
  p_move_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q));

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] c_data,
  input  logic              c_perr,
  input  logic              c_ferr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_ovr
);
  logic take;
  assign take = rd_valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_perr  <= 1'b0;
      rd_ferr  <= 1'b0;
      rd_ovr   <= 1'b0;
    end else if (done) begin
      rd_valid <= 1'b1;
      rd_data  <= c_data;
      rd_perr  <= c_perr;
      rd_ferr  <= c_ferr;
      if (rd_valid && !rd_ready) rd_ovr <= 1'b1;
      else if (take)             rd_ovr <= 1'b0;
    end else if (take) begin
      rd_valid <= 1'b0;
      rd_ovr   <= 1'b0;
    end
  end

  // R8: overrun only reported alongside a held character
  p_ovr_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ovr |-> rd_valid);

  // R8: completion over an untaken character raises overrun
  p_overrun_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_valid && !rd_ready) |=> rd_ovr);

  // R7: a take with no new character empties the holding register
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !done) |=> (!rd_valid && !rd_ovr));

  // R9: held character is stable until taken or replaced
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !done) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_perr) && $stable(rd_ferr)));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic [1:0]        lc_wlen,
  input  logic              lc_par_en,
  input  logic              lc_par_even,
  input  logic              lc_par_stick,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_ovr
);
  logic              rxd_s;
  logic              done;
  logic [DATA_W-1:0] c_data;
  logic              c_perr;
  logic              c_ferr;
  rx_cfg_t           cfg;

  assign cfg = '{wlen: lc_wlen, par_en: lc_par_en, par_even: lc_par_even,
                 par_stick: lc_par_stick};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rxd), .d_sync(rxd_s)
  );

  uart_rx_shifter #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_s(rxd_s), .cfg(cfg),
    .done(done), .c_data(c_data), .c_perr(c_perr), .c_ferr(c_ferr)
  );

  uart_rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(done), .c_data(c_data),
    .c_perr(c_perr), .c_ferr(c_ferr), .rd_ready(rx_ready),
    .rd_valid(rx_valid), .rd_data(rx_data), .rd_perr(rx_perr),
    .rd_ferr(rx_ferr), .rd_ovr(rx_ovr)
  );
endmodule

// File: tb/uart_rx_dbuf_tb.sv
module uart_rx_dbuf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int OS         = 16;
  localparam int BIT_CYC    = OS * TICK_DIV;

  typedef struct packed {
    logic [1:0] wl;
    logic       pen;
    logic       even;
    logic       stick;
    logic [7:0] d;
    logic       flip;
    logic       stop_low;
    logic [7:0] exp_d;
    logic       exp_pe;
    logic       exp_fe;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b1, 8'h0A, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       rxd = 1'b1;
  logic [1:0] lc_wlen = 2'd3;
  logic       lc_par_en = 1'b0;
  logic       lc_par_even = 1'b0;
  logic       lc_par_stick = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       rx_perr;
  logic       rx_ferr;
  logic       rx_ovr;
  int         tdiv = 0;
  int         total = 0;
  int         bad = 0;
  bit         ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  assign baud_tick = (tdiv == TICK_DIV - 1);

  uart_rx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .lc_wlen(lc_wlen), .lc_par_en(lc_par_en), .lc_par_even(lc_par_even),
    .lc_par_stick(lc_par_stick), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b);
    rxd = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_char(input logic [1:0] wl, input logic pen, input logic even,
                           input logic stick, input logic [7:0] d,
                           input logic flip, input logic stop_low);
    int   nb;
    logic [7:0] dm;
    logic p;
    nb = 5 + int'(wl);
    dm = d & 8'((1 << nb) - 1);
    p  = stick ? ~even : ((^dm) ^ ~even);
    p  = p ^ flip;
    lc_wlen = wl; lc_par_en = pen; lc_par_even = even; lc_par_stick = stick;
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(dm[i]);
    if (pen) hold_bit(p);
    hold_bit(~stop_low);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_valid == 0, "R1 valid", rx_valid, 0);
    chk({rx_perr, rx_ferr, rx_ovr} == 0, "R1 flags", {rx_perr, rx_ferr, rx_ovr}, 0);

    // R3 R4 R5 R6 R7 vector walk
    for (int v = 0; v < NV; v++) begin
      send_char(VECS[v].wl, VECS[v].pen, VECS[v].even, VECS[v].stick,
                VECS[v].d, VECS[v].flip, VECS[v].stop_low);
      chk(rx_valid == 1, "R6 valid", rx_valid, 1);
      chk(rx_data == VECS[v].exp_d, "R3 data", rx_data, VECS[v].exp_d);
      chk(rx_perr == VECS[v].exp_pe, "R4 perr", rx_perr, VECS[v].exp_pe);
      chk(rx_ferr == VECS[v].exp_fe, "R5 ferr", rx_ferr, VECS[v].exp_fe);
      chk(rx_ovr == 0, "R8 no ovr", rx_ovr, 0);
      read_pulse();
      chk(rx_valid == 0, "R7 cleared", rx_valid, 0);
    end

    // R2 false start: short low glitch
    rxd = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CYC) @(negedge clk);
    chk(rx_valid == 0, "R2 false start", rx_valid, 0);
    send_char(2'd3, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0);
    chk(rx_data == 8'hC3 && rx_valid, "R2 recover", rx_data, 8'hC3);
    read_pulse();

    // R6 double buffering: read first char while second arrives
    send_char(2'd3, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
    fork
      send_char(2'd3, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
      begin
        repeat (BIT_CYC * 4) @(negedge clk);
        chk(rx_data == 8'h11, "R6 first held", rx_data, 8'h11);
        read_pulse();
        chk(rx_valid == 0, "R6 taken mid-char", rx_valid, 0);
      end
    join
    chk(rx_valid && rx_data == 8'h22, "R6 second", rx_data, 8'h22);
    chk(rx_ovr == 0, "R6 no overrun", rx_ovr, 0);
    read_pulse();

    // R9 stability and R8 overrun
    send_char(2'd3, 1'b1, 1'b1, 1'b0, 8'h33, 1'b1, 1'b0);
    repeat (BIT_CYC * 3) @(negedge clk);
    chk(rx_valid && rx_data == 8'h33 && rx_perr, "R9 stable", rx_data, 8'h33);
    send_char(2'd3, 1'b1, 1'b1, 1'b0, 8'h44, 1'b0, 1'b0);
    chk(rx_ovr == 1, "R8 ovr set", rx_ovr, 1);
    chk(rx_data == 8'h44, "R8 overwrite", rx_data, 8'h44);
    chk(rx_perr == 0, "R8 flags replaced", rx_perr, 0);
    read_pulse();
    chk(rx_valid == 0 && rx_ovr == 0, "R7 ovr cleared", {rx_valid, rx_ovr}, 0);

    // R7 ready with nothing held
    read_pulse();
    chk(rx_valid == 0, "R7 idle ready", rx_valid, 0);
    send_char(2'd1, 1'b0, 1'b0, 1'b0, 8'h15, 1'b0, 1'b0);
    chk(rx_valid && rx_data == 8'h15 && !rx_ovr, "R7 after idle ready", rx_data, 8'h15);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule